// File: doc/BRIEF.md
# PCM Sample Playback FIFO Controller

This block plays back 8-bit unsigned audio samples that a host streams in over a small byte-wide register bus. Each byte written to the data offset enters a first-in first-out buffer. A reload timer, which the host programs in microsecond units, drains the buffer at a steady rate. On every timer expiry the oldest sample moves into the DAC holding register. The DAC output is the held byte with its top bit flipped, so it can be read as a two's-complement value centred on zero.

Software keeps the buffer topped up by watching two sticky flags. The low-water flag sets when the occupancy after an expiry exactly equals four times a programmed threshold byte. The data-ready flag sets on every expiry. Each flag has its own enable bit in the control register, and a master enable gates the single interrupt line. The host reads a status byte that combines the sticky flags with the live full and empty conditions of the buffer.

Top module: `pcm_fifo_player`

## Requirements
- R1: A write to offset 0 appends the byte to the buffer, which holds 2^DEPTH_LOG2 entries. A write that arrives while the buffer already holds that many entries is discarded, even if an expiry falls in the same cycle.
- R2: A read of offset 0 returns 0x00 and clears the data-ready flag. If a timer expiry falls in the same cycle, the flag stays set.
- R3: A read of offset 2 returns the status byte: bit 0 is the master enable, bit 1 is low-water, bit 2 is buffer empty, bit 3 is buffer full, bit 4 is data-ready, and bits 7:5 are zero.
- R4: A write to offset 2 stores the control bits: bit 0 is the master enable, bit 1 enables the low-water source, and bit 4 enables the data-ready source. If the written bit 1 is 0, the low-water flag clears, unless an expiry in the same cycle sets it again.
- R5: `irq` is high exactly when the master enable is set and at least one enabled source flag is set. It follows the register state one cycle after the bus edge or expiry that changed it.
- R6: A write to offset 3 stores a reload value R. If R is 0 the timer stops. If R is nonzero the timer restarts, and an expiry takes effect R*CLK_PER_US clocks after the write edge and every R*CLK_PER_US clocks after that. A read of offset 3 returns R.
- R7: A write to offset 4 sets the low-water threshold to four times the written byte.
- R8: On each expiry the head of the buffer moves into the DAC register, provided the buffer is not empty, and data-ready is set in every case.
- R9: On an expiry, low-water sets when the occupancy after that cycle's pop, and any same-cycle accepted push, equals the threshold.
- R10: `dac_out` equals the held byte XOR 0x80.
- R11: After reset the buffer is empty, all flags, control bits and the reload value are 0, `dac_out` is -128, and `irq` is low. Reads of offsets 1, 4, 5, 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high, otherwise 0 |
| dac_out | output | 8 | Signed DAC sample |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same clock: a timer expiry with a host read of offset 0, and a timer expiry with a host push. The bench starts the timer and counts cycles from the reload write edge so that the bus strobe is captured on exactly the edge where the expiry takes effect. In the first case, data-ready must still be set afterwards, as seen through `irq` with only that source enabled. In the second case, the low-water flag must reflect an occupancy that includes both the pop and the push.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    localparam logic [2:0] OFS_DATA   = 3'd0;
    localparam logic [2:0] OFS_STAT   = 3'd2;
    localparam logic [2:0] OFS_RELOAD = 3'd3;
    localparam logic [2:0] OFS_THRESH = 3'd4;

    typedef struct packed {
        logic       en;       // master interrupt enable
        logic       lw_en;    // low-water source enable
        logic       dr_en;    // data-ready source enable
        logic       lw;       // sticky low-water flag
        logic       dr;       // sticky data-ready flag
        logic [7:0] reload;
        logic [7:0] thresh;
        logic [7:0] dac;
    } pcm_regs_t;
endpackage

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo #(
    parameter int DEPTH_LOG2 = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [7:0]            wdata,
    input  logic                  pop,
    output logic [7:0]            head,
    output logic [DEPTH_LOG2:0]   occ,
    output logic                  full,
    output logic                  empty
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int PW    = DEPTH_LOG2 + 1;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
    logic          push_ok, pop_ok;

    always_comb begin
        occ     = wr_q - rd_q;
        full    = (occ == PW'(DEPTH));
        empty   = (occ == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        wr_d    = wr_q + PW'(push_ok);
        rd_d    = rd_q + PW'(pop_ok);
        head    = mem[rd_q[DEPTH_LOG2-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            wr_q <= wr_d;
            rd_q <= rd_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_q[DEPTH_LOG2-1:0]] <= wdata;
    end
endmodule

// File: rtl/pcm_tick_timer.sv
module pcm_tick_timer #(
    parameter int CLK_PER_US = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] reload,
    output logic       expire
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    logic [PRE_W-1:0] pre_q, pre_d;
    logic [7:0]       cnt_q, cnt_d;
    logic             us;

    always_comb begin
        us     = (pre_q == PRE_W'(CLK_PER_US - 1));
        expire = (reload != 8'd0) && us && (cnt_q == reload - 8'd1);
        pre_d  = pre_q;
        cnt_d  = cnt_q;
        if (load || reload == 8'd0) begin
            pre_d = '0;
            cnt_d = '0;
        end else begin
            pre_d = us ? '0 : pre_q + PRE_W'(1);
            if (us) cnt_d = expire ? 8'd0 : cnt_q + 8'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pcm_fifo_player.sv
module pcm_fifo_player
    import pcm_pkg::*;
#(
    parameter int DEPTH_LOG2 = 11,
    parameter int CLK_PER_US = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    output logic [7:0]  dac_out,
    output logic        irq
);
    localparam int OCC_W = DEPTH_LOG2 + 1;
    localparam int CMP_W = (OCC_W > 10) ? OCC_W : 10;

    pcm_regs_t        q, d;
    logic [7:0]       head;
    logic [OCC_W-1:0] occ, occ_next;
    logic             fifo_full, fifo_empty, tick;
    logic             wr_data, rd_data, wr_ctrl, wr_reload, wr_thresh;
    logic [7:0]       reload_val;
    logic             dr_flag;

    assign wr_data    = bus_wr && bus_addr == OFS_DATA;
    assign rd_data    = bus_rd && bus_addr == OFS_DATA;
    assign wr_ctrl    = bus_wr && bus_addr == OFS_STAT;
    assign wr_reload  = bus_wr && bus_addr == OFS_RELOAD;
    assign wr_thresh  = bus_wr && bus_addr == OFS_THRESH;
    assign reload_val = q.reload;
    assign dr_flag    = q.dr;

    pcm_sample_fifo #(.DEPTH_LOG2(DEPTH_LOG2)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_data),
        .wdata (bus_wdata),
        .pop   (tick),
        .head  (head),
        .occ   (occ),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pcm_tick_timer #(.CLK_PER_US(CLK_PER_US)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_reload),
        .reload (q.reload),
        .expire (tick)
    );

    always_comb begin
        occ_next = occ + OCC_W'(wr_data && !fifo_full) - OCC_W'(tick && !fifo_empty);
        d = q;
        if (wr_ctrl) begin
            d.en    = bus_wdata[0];
            d.lw_en = bus_wdata[1];
            d.dr_en = bus_wdata[4];
            if (!bus_wdata[1]) d.lw = 1'b0;
        end
        if (rd_data)   d.dr     = 1'b0;
        if (wr_reload) d.reload = bus_wdata;
        if (wr_thresh) d.thresh = bus_wdata;
        if (tick) begin
            if (!fifo_empty) d.dac = head;
            if (CMP_W'(occ_next) == CMP_W'({q.thresh, 2'b00})) d.lw = 1'b1;
            d.dr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            case (bus_addr)
                OFS_STAT:   bus_rdata = {3'b000, q.dr, fifo_full, fifo_empty, q.lw, q.en};
                OFS_RELOAD: bus_rdata = q.reload;
                default:    bus_rdata = 8'h00;
            endcase
        end
        dac_out = {~q.dac[7], q.dac[6:0]};
        irq     = q.en && ((q.lw && q.lw_en) || (q.dr && q.dr_en));
    end
endmodule

// File: rtl/pcm_fifo_player_chk.sv
module pcm_fifo_player_chk #(
    parameter int DEPTH_LOG2 = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          bus_addr,
    input logic                bus_wr,
    input logic [7:0]          bus_wdata,
    input logic                bus_rd,
    input logic                irq,
    input logic [DEPTH_LOG2:0] occ,
    input logic                full,
    input logic                tick,
    input logic [7:0]          reload,
    input logic                dr
);
    localparam int OCC_W = DEPTH_LOG2 + 1;

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(1 << DEPTH_LOG2));

    a_r1_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && bus_wr && bus_addr == 3'd0 && !tick) |=> full);

    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd0 && !tick) |=> !dr);

    a_r5_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2 && !bus_wdata[0]) |=> !irq);

    a_r6_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == 8'd0) |-> !tick);

    a_r8_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> dr);
endmodule

bind pcm_fifo_player pcm_fifo_player_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .irq       (irq),
    .occ       (occ),
    .full      (fifo_full),
    .tick      (tick),
    .reload    (reload_val),
    .dr        (dr_flag)
);

// File: tb/sim_pcm_fifo_player.sv
module sim_pcm_fifo_player;
    localparam int DL = 4;
    localparam int P  = 2;
    localparam int N  = 1 << DL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, dac_out;
    logic       irq;
    int         checks = 0, errors = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    pcm_fifo_player #(.DEPTH_LOG2(DL), .CLK_PER_US(P)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .dac_out(dac_out), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state, R3 empty bit
        rd(3'd2, rv); chk("R3 reset status", rv, 8'h04);
        rd(3'd3, rv); chk("R11 reset reload", rv, 0);
        chk("R11 reset dac", dac_out, 8'h80);
        chk("R11 reset irq", irq, 0);

        // R1 fill past capacity
        for (int i = 0; i <= N; i++) wr(3'd0, pat(i));
        rd(3'd2, rv); chk("R1 R3 full status", rv, 8'h08);

        // R8 R10 drain at one expiry per 2 clocks
        wr(3'd3, 8'd1);
        for (int k = 0; k < N; k++) begin
            repeat (P) @(posedge clk); @(negedge clk);
            chk("R8 R10 dac sample", dac_out, pat(k) ^ 8'h80);
        end
        repeat (P) @(posedge clk); @(negedge clk);
        chk("R1 dropped byte not played", dac_out, pat(N - 1) ^ 8'h80);
        wr(3'd3, 8'd0);
        rd(3'd2, rv); chk("R3 R9 status after drain", rv, 8'h16);

        // R4 R2 clear flags
        wr(3'd2, 8'h00);
        rd(3'd0, rv); chk("R2 data read value", rv, 0);
        rd(3'd2, rv); chk("R4 R2 flags cleared", rv, 8'h04);

        // R7 R9 R5 threshold 4 with six queued
        wr(3'd4, 8'd1);
        for (int i = 0; i < 6; i++) wr(3'd0, pat(i + 40));
        wr(3'd2, 8'h03);
        wr(3'd3, 8'd4);
        repeat (4 * P - 1) @(posedge clk); @(negedge clk);
        chk("R6 no expiry before period", dac_out, pat(N - 1) ^ 8'h80);
        @(posedge clk); @(negedge clk);
        chk("R9 occupancy 5 no low-water", irq, 0);
        rd(3'd2, rv); chk("R3 status mid", rv, 8'h11);
        repeat (4 * P - 1) @(posedge clk); @(negedge clk);
        chk("R9 R5 low-water irq", irq, 1);
        rd(3'd2, rv); chk("R9 status low-water", rv, 8'h13);
        rd(3'd3, rv); chk("R6 reload readback", rv, 8'd4);
        wr(3'd3, 8'd0);
        wr(3'd2, 8'h01);
        wr(3'd2, 8'h03);
        chk("R4 low-water cleared by control", irq, 0);

        // R5 R2 data-ready source
        wr(3'd2, 8'h11);
        chk("R5 data-ready irq", irq, 1);
        rd(3'd0, rv);
        chk("R2 read clears data-ready", irq, 0);

        // R6 period sweep, irq tracks data-ready
        for (int r = 1; r <= 5; r++) begin
            if (r != 4) begin
                wr(3'd3, 8'(r));
                repeat (r * P - 1) @(posedge clk); @(negedge clk);
                chk("R6 before expiry", irq, 0);
                @(posedge clk); @(negedge clk);
                chk("R6 at expiry", irq, 1);
                wr(3'd3, 8'd0);
                rd(3'd0, rv);
            end
        end

        // R2 read coincident with expiry
        wr(3'd3, 8'd2);
        repeat (2 * P - 1) @(posedge clk); @(negedge clk);
        rd(3'd0, rv);
        chk("R2 expiry wins over read clear", irq, 1);
        wr(3'd3, 8'd0);
        rd(3'd2, rv); chk("R3 empty again", rv, 8'h15);

        // R9 push coincident with expiry: 4 - 1 + 1 = 4
        for (int i = 0; i < 4; i++) wr(3'd0, pat(i + 80));
        wr(3'd3, 8'd3);
        repeat (3 * P - 1) @(posedge clk); @(negedge clk);
        wr(3'd0, 8'h55);
        rd(3'd2, rv); chk("R9 push plus pop hits threshold", rv, 8'h13);
        chk("R8 head moved to dac", dac_out, pat(80) ^ 8'h80);
        wr(3'd3, 8'd0);

        // R11 R7 unused offsets
        for (int a = 1; a < 8; a++) begin
            if (a != 2 && a != 3) begin
                rd(3'(a), rv); chk("R11 R7 zero offset", rv, 0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule